// File: doc/BRIEF.md
# Tagged-FIFO Serial Receiver

This block is an asynchronous serial receiver that oversamples the incoming line sixteen times per bit. It turns each frame into a 12-bit entry and places it in a small FIFO. Each entry holds the received character together with four flags: framing error, parity error, overrun and line break. Software reads the character and its flags in one access, so a flag always belongs to the character it arrived with.

The frame format comes in on a configuration byte driven by a neighbouring control-register block. The byte sets the word length, parity enable, parity sense, the second stop bit and the FIFO enable. A divisor input sets the bit rate. A small read port exposes two words: the head of the FIFO at byte offset 0x00 and a status word at offset 0x10.

The receiver gives an interrupt unit two separate conditions:
- a receive request, raised when enough characters are waiting;
- a receive timeout, raised when characters sit in the FIFO while the line stays quiet.

Top module: `uart_rx_tagged`

## Requirements
- R1: A read at offset 0x00 returns the head entry: character in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11. Bits 15:12 read 0. A read with `rdEn` high at offset 0x00 removes that entry.
- R2: At offset 0x10, bit 4 reads 1 while the FIFO holds no entry and 0 otherwise. Reading this offset never removes an entry.
- R3: `cfgFrame` bit 4 set gives a 16-entry FIFO. With bit 4 clear the FIFO holds a single entry.
- R4: `cfgFrame` bits 6:5 select the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data arrives LSB first. Unused high character bits read 0.
- R5: `cfgFrame` bit 1 enables a parity bit after the data. Bit 2 set expects even parity and clear expects odd. A mismatch sets bit 9 of the entry.
- R6: `cfgFrame` bit 3 set expects two stop bits. A stop bit sampled low sets the framing flag (bit 8).
- R7: One bit lasts 16×(`cfgDivisor`+1) clock cycles, so `cfgDivisor` holds N−1.
- R8: A falling edge starts a frame only if the line is still low at the eighth oversample tick. A shorter low pulse stores nothing.
- R9: A line held low through the whole frame, stop bit(s) included, stores one entry that reads 0x900: break and framing set, parity and data 0.
- R10: A frame that completes while the FIFO is full is discarded and the stored entries are left unchanged. The next entry that is stored carries the overrun flag (bit 10).
- R11: `rxReq` is high when the FIFO holds at least 8 entries in 16-entry mode, or at least 1 entry in single-entry mode.
- R12: `rxTimeout` rises after 32 idle bit periods with a non-empty FIFO. It falls after a data read, or when a new frame begins.
- R13: A data read of an empty FIFO returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial line, idle high |
| cfgFrame | input | 8 | Frame control: [1] parity on, [2] even, [3] two stops, [4] FIFO on, [6:5] word length |
| cfgDivisor | input | DIV_W | Bit-rate divisor minus one |
| rdEn | input | 1 | Read strobe; pops at offset 0x00 |
| rdAddr | input | 5 | Byte offset of the read |
| rdData | output | 16 | Read data for `rdAddr` |
| rxReq | output | 1 | Receive request |
| rxTimeout | output | 1 | Receive idle timeout |

## Verification
The bench goes after the corner cases of this block and checks what a faulty design would do in each:
- **Word length and parity.** The bench walks every word length and both parity senses. A shifted or unmasked character shows stale high bits, and an inverted parity sense flags good frames.
- **False start.** A short low pulse must leave the FIFO empty. A receiver that skips mid-bit validation would store a spurious entry.
- **Break.** A held-low line must give exactly one 0x900 entry. A design that re-arms while the line is still low would store a string of zero entries.
- **Overrun.** Both FIFO depths are driven past full. A wrong design either overwrites a stored character or drops the overrun flag from the next entry.
- **Timeout.** The timeout is sampled on both sides of the 32-bit-period window, and an empty read must leave the FIFO pointers unchanged.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int FRAME_PAR_EN   = 1;
  localparam int FRAME_PAR_EVEN = 2;
  localparam int FRAME_TWO_STOP = 3;
  localparam int FRAME_FIFO_EN  = 4;
  localparam int FRAME_WLEN_LO  = 5;

  localparam logic [4:0] OFS_DATA   = 5'h00;
  localparam logic [4:0] OFS_STATUS = 5'h10;
  localparam int STATUS_EMPTY_BIT = 4;

  // Stored word; field order fixes the bit positions software decodes.
  typedef struct packed {
    logic       brk;
    logic       ovr;
    logic       par;
    logic       frm;
    logic [7:0] chr;
  } rx_entry_t;

  // Strobes from the bit-timing control to the datapath.
  typedef struct packed {
    logic tick;
    logic frameStart;
    logic dataBit;
    logic parityBit;
    logic stopBit;
    logic lastStop;
    logic lineIdle;
  } rx_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_HOLD
  } rx_state_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic [1:0]       wordSel,
  input  logic             parityEn,
  input  logic             twoStop,
  output rx_strobe_t       strobes
);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  rx_state_t        state;
  logic [3:0]       sub;
  logic [2:0]       bitIdx;
  logic             stopIdx;
  logic [2:0]       lastBitIdx;

  assign tick       = (divCnt == '0);
  assign lastBitIdx = 3'd4 + {1'b0, wordSel};

  // Oversample tick: one pulse every cfgDivisor+1 clocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? cfgDivisor : divCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sub     <= '0;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!lineIn) begin
            state <= ST_START;
            sub   <= '0;
          end
        end
        ST_START: begin
          if (sub == 4'd7) begin
            sub    <= '0;
            bitIdx <= '0;
            state  <= lineIn ? ST_IDLE : ST_DATA;
          end else sub <= sub + 4'd1;
        end
        ST_DATA: begin
          if (sub == 4'd15) begin
            sub <= '0;
            if (bitIdx == lastBitIdx) begin
              stopIdx <= 1'b0;
              state   <= parityEn ? ST_PARITY : ST_STOP;
            end else bitIdx <= bitIdx + 3'd1;
          end else sub <= sub + 4'd1;
        end
        ST_PARITY: begin
          if (sub == 4'd15) begin
            sub     <= '0;
            stopIdx <= 1'b0;
            state   <= ST_STOP;
          end else sub <= sub + 4'd1;
        end
        ST_STOP: begin
          if (sub == 4'd15) begin
            sub <= '0;
            if (twoStop && !stopIdx) stopIdx <= 1'b1;
            else state <= lineIn ? ST_IDLE : ST_HOLD;
          end else sub <= sub + 4'd1;
        end
        ST_HOLD: begin
          if (lineIn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.tick       = tick;
    strobes.lineIdle   = (state == ST_IDLE);
    strobes.frameStart = tick && (state == ST_START) && (sub == 4'd7) && !lineIn;
    strobes.dataBit    = tick && (state == ST_DATA)   && (sub == 4'd15);
    strobes.parityBit  = tick && (state == ST_PARITY) && (sub == 4'd15);
    strobes.stopBit    = tick && (state == ST_STOP)   && (sub == 4'd15);
    strobes.lastStop   = strobes.stopBit && (!twoStop || stopIdx);
  end

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int REQ_LEVEL    = 8,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  rx_strobe_t strobes,
  input  logic [1:0] wordSel,
  input  logic       parityEven,
  input  logic       fifoEn,
  input  logic       popReq,
  output rx_entry_t  headEntry,
  output logic       fifoEmpty,
  output logic       rxReq,
  output logic       rxTimeout
);

  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = AW + 1;
  localparam int TO_TICKS = TIMEOUT_BITS * 16;
  localparam int TW       = $clog2(TO_TICKS + 1);

  logic [7:0]    shiftReg;
  logic          parAcc, zeroAcc, frmAcc, parErr, lostFlag;
  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count, depthNow;
  logic [TW-1:0] toCnt;
  logic          push, pop, full, wrOk, stopLowNow;
  rx_entry_t     newEntry;

  // Frame assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      zeroAcc  <= 1'b1;
      frmAcc   <= 1'b0;
      parErr   <= 1'b0;
    end else if (strobes.frameStart) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      zeroAcc  <= 1'b1;
      frmAcc   <= 1'b0;
      parErr   <= 1'b0;
    end else if (strobes.dataBit) begin
      shiftReg <= {lineIn, shiftReg[7:1]};
      parAcc   <= parAcc ^ lineIn;
      zeroAcc  <= zeroAcc & ~lineIn;
    end else if (strobes.parityBit) begin
      parErr  <= (parAcc ^ lineIn) ^ ~parityEven;
      zeroAcc <= zeroAcc & ~lineIn;
    end else if (strobes.stopBit) begin
      frmAcc  <= frmAcc | ~lineIn;
      zeroAcc <= zeroAcc & ~lineIn;
    end
  end

  assign stopLowNow   = ~lineIn;
  assign newEntry.chr = shiftReg >> (2'd3 - wordSel);
  assign newEntry.frm = frmAcc | stopLowNow;
  assign newEntry.brk = zeroAcc & stopLowNow;
  assign newEntry.par = parErr & ~(zeroAcc & stopLowNow);
  assign newEntry.ovr = lostFlag;

  // FIFO
  assign depthNow  = fifoEn ? CW'(DEPTH) : CW'(1);
  assign fifoEmpty = (count == '0);
  assign full      = (count >= depthNow);
  assign push      = strobes.lastStop;
  assign pop       = popReq && !fifoEmpty;
  assign wrOk      = push && !full;

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      lostFlag <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      if (wrOk && !pop)      count <= count + 1'b1;
      else if (pop && !wrOk) count <= count - 1'b1;
      if (wrOk)      lostFlag <= 1'b0;
      else if (push) lostFlag <= 1'b1;
    end
  end

  assign headEntry = fifoEmpty ? '0 : mem[rdPtr];
  assign rxReq     = fifoEn ? (count >= CW'(REQ_LEVEL)) : !fifoEmpty;

  // Idle timeout, counted in oversample ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) toCnt <= '0;
    else if (!strobes.lineIdle || fifoEmpty || pop) toCnt <= '0;
    else if (strobes.tick && toCnt != TW'(TO_TICKS)) toCnt <= toCnt + 1'b1;
  end

  assign rxTimeout = (toCnt == TW'(TO_TICKS));

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R3
  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !rxReq); // R11
  AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxTimeout |-> !fifoEmpty); // R12
  AST_READ_CLEARS_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> !rxTimeout); // R12
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count))); // R10
  AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEmpty && headEntry.brk) |-> headEntry.frm); // R9

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int FIFO_DEPTH   = 16,
  parameter int REQ_LEVEL    = 8,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [7:0]       cfgFrame,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             rdEn,
  input  logic [4:0]       rdAddr,
  output logic [15:0]      rdData,
  output logic             rxReq,
  output logic             rxTimeout
);

  logic [1:0] lineSync;
  rx_strobe_t strobes;
  rx_entry_t  headEntry;
  logic       fifoEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineSync <= 2'b11;
    else       lineSync <= {lineSync[0], rxLine};
  end

  uart_rx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineSync[1]),
    .cfgDivisor (cfgDivisor),
    .wordSel    (cfgFrame[FRAME_WLEN_LO +: 2]),
    .parityEn   (cfgFrame[FRAME_PAR_EN]),
    .twoStop    (cfgFrame[FRAME_TWO_STOP]),
    .strobes    (strobes)
  );

  uart_rx_datapath #(
    .DEPTH        (FIFO_DEPTH),
    .REQ_LEVEL    (REQ_LEVEL),
    .TIMEOUT_BITS (TIMEOUT_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineSync[1]),
    .strobes    (strobes),
    .wordSel    (cfgFrame[FRAME_WLEN_LO +: 2]),
    .parityEven (cfgFrame[FRAME_PAR_EVEN]),
    .fifoEn     (cfgFrame[FRAME_FIFO_EN]),
    .popReq     (rdEn && (rdAddr == OFS_DATA)),
    .headEntry  (headEntry),
    .fifoEmpty  (fifoEmpty),
    .rxReq      (rxReq),
    .rxTimeout  (rxTimeout)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == OFS_DATA)        rdData = {4'b0, headEntry};
    else if (rdAddr == OFS_STATUS) rdData[STATUS_EMPTY_BIT] = fifoEmpty;
  end

endmodule

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [7:0]  cfgFrame = 8'h70;
  logic [15:0] cfgDivisor = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        rxReq, rxTimeout;
  int          errors = 0;
  int          checks = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  uart_rx_tagged dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cfgFrame(cfgFrame),
    .cfgDivisor(cfgDivisor), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .rxReq(rxReq), .rxTimeout(rxTimeout)
  );

  // {div[23:22], wsel[21:20], parEn[19], parEven[18], twoStop[17], badPar[16], badStop[15], data[7:0]}
  localparam logic [23:0] VEC [8] = '{
    {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 8'hA5}, // R4 8 bits
    {2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0, 8'hDA}, // R4 7 bits, R5 even, R7 div 1
    {2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 8'h13}, // R4 5 bits, R5 odd, R7 div 2
    {2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 7'd0, 8'h2C}, // R5 bad parity, 6 bits
    {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd0, 8'h81}, // R6 stop low
    {2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0, 8'hFF}, // R6 two stops
    {2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 8'h00}, // R5 odd, zero data
    {2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 7'd0, 8'h7F}  // R6 two stops low
  };

  function automatic logic [15:0] expWord(input logic [23:0] v);
    logic [7:0] mask;
    mask = 8'hFF >> (2'd3 - v[21:20]);
    return {6'b0, v[19] & v[16], v[15], v[7:0] & mask};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int div, input logic [1:0] wsel, input logic pEn,
                        input logic pEven, input logic two, input logic fifoOn);
    @(negedge clk);
    cfgDivisor = 16'(div);
    cfgFrame   = {1'b0, wsel, fifoOn, two, pEven, pEn, 1'b0};
  endtask

  task automatic idleBits(input int n);
    repeat (n * 16 * (int'(cfgDivisor) + 1)) @(negedge clk);
  endtask

  task automatic driveBit(input logic v);
    rxLine = v;
    repeat (16 * (int'(cfgDivisor) + 1)) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic badStop);
    int w;
    logic [7:0] m;
    logic pb;
    w  = 5 + int'(cfgFrame[6:5]);
    m  = d & (8'hFF >> (2'd3 - cfgFrame[6:5]));
    pb = cfgFrame[2] ? ^m : ~(^m);
    if (badPar) pb = ~pb;
    @(negedge clk);
    driveBit(1'b0);
    for (int i = 0; i < w; i++) driveBit(d[i]);
    if (cfgFrame[1]) driveBit(pb);
    driveBit(~badStop);
    if (cfgFrame[3]) driveBit(~badStop);
    rxLine = 1'b1;
  endtask

  task automatic readData(output logic [15:0] v);
    @(negedge clk);
    rdAddr = 5'h00;
    rdEn   = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peekEmpty(output logic e);
    @(negedge clk);
    rdAddr = 5'h10;
    #1 e = rdData[4];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic e;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    peekEmpty(e);
    chk("R2 empty after reset", {15'b0, e}, 16'd1);
    @(negedge clk); rdAddr = 5'h00; #1;
    chk("R13 data reads 0 when empty", rdData, 16'h0000);
    chk("R11 no request after reset", {15'b0, rxReq}, 16'd0);
    chk("R12 no timeout after reset", {15'b0, rxTimeout}, 16'd0);

    // False start: 4 ticks low, then high
    setCfg(0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    idleBits(3);
    peekEmpty(e);
    chk("R8 short pulse stores nothing", {15'b0, e}, 16'd1);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      setCfg(int'(VEC[i][23:22]), VEC[i][21:20], VEC[i][19], VEC[i][18], VEC[i][17], 1'b1);
      idleBits(2);
      sendFrame(VEC[i][7:0], VEC[i][16], VEC[i][15]);
      idleBits(2);
      peekEmpty(e);
      chk("R2 entry available", {15'b0, e}, 16'd0);
      readData(v);
      chk("R1 vector word", v, expWord(VEC[i]));
      peekEmpty(e);
      chk("R1 read removed entry", {15'b0, e}, 16'd1);
    end

    // Break: line low for 12 bit periods
    setCfg(0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    rxLine = 1'b0;
    idleBits(12);
    rxLine = 1'b1;
    idleBits(3);
    readData(v);
    chk("R9 break entry", v, 16'h0900);
    peekEmpty(e);
    chk("R9 single break entry", {15'b0, e}, 16'd1);

    // Single-entry mode overrun
    setCfg(0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    idleBits(2);
    sendFrame(8'h41, 1'b0, 1'b0);
    idleBits(1);
    chk("R11 request at one entry in single mode", {15'b0, rxReq}, 16'd1);
    sendFrame(8'h42, 1'b0, 1'b0);
    idleBits(1);
    readData(v);
    chk("R3 R10 single entry kept first char", v, 16'h0041);
    peekEmpty(e);
    chk("R3 lost char not stored", {15'b0, e}, 16'd1);
    sendFrame(8'h43, 1'b0, 1'b0);
    idleBits(1);
    readData(v);
    chk("R10 overrun flagged on next entry", v, 16'h0443);

    // 16-entry mode fill and overflow
    setCfg(0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    for (int i = 0; i < 17; i++) begin
      sendFrame(8'(i * 7 + 3), 1'b0, 1'b0);
      idleBits(1);
      if (i == 6) chk("R11 no request at 7 entries", {15'b0, rxReq}, 16'd0);
      if (i == 7) chk("R11 request at 8 entries", {15'b0, rxReq}, 16'd1);
    end
    for (int i = 0; i < 16; i++) begin
      readData(v);
      chk("R3 deep FIFO order", v, {8'h00, 8'(i * 7 + 3)});
    end
    peekEmpty(e);
    chk("R10 seventeenth char dropped", {15'b0, e}, 16'd1);
    sendFrame(8'h5E, 1'b0, 1'b0);
    idleBits(1);
    readData(v);
    chk("R10 overrun after deep overflow", v, 16'h045E);

    // Timeout at divisor 0: 32 bits = 512 clocks of idle
    sendFrame(8'h99, 1'b0, 1'b0);
    repeat (400) @(negedge clk);
    chk("R12 no timeout before window", {15'b0, rxTimeout}, 16'd0);
    repeat (130) @(negedge clk);
    chk("R12 timeout after window", {15'b0, rxTimeout}, 16'd1);
    readData(v);
    chk("R12 timed-out char", v, 16'h0099);
    chk("R12 timeout cleared by read", {15'b0, rxTimeout}, 16'd0);

    // Empty read has no effect
    readData(v);
    chk("R13 empty read returns 0", v, 16'h0000);
    sendFrame(8'h3C, 1'b0, 1'b0);
    idleBits(1);
    readData(v);
    chk("R13 FIFO intact after empty read", v, 16'h003C);
    peekEmpty(e);
    chk("R13 empty again", {15'b0, e}, 16'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule